// File: doc/BRIEF.md
# Program Memory Read Protection Gate

This block stands between an on-chip program memory and the three agents that can read it: the internal software table-read path, an external device programmer and an in-system debugger. It arbitrates among them, issues at most one memory read per cycle and returns each reply through a register. The reply is either the memory data or forced zeros, depending on a protection fuse and on what was asked for.

The protection fuse is active low and can only be cleared. Software may clear it. Only the erase-complete pulse, which marks the end of a full device erase, returns it to the unprotected value. While the fuse is clear, the programmer sees zeros for every program memory word, but it still sees true data from the configuration block. Internal table reads are never masked. Debugger requests are answered with a denial and no memory access takes place. The block also tracks whether a program image is present: a commit pulse sets that flag and the erase pulse clears it.

The fuse state machine has two states. FUSE_OPEN holds fuse value 1 (unprotected). FUSE_LOCKED holds fuse value 0 (protected). There are two transitions:
- LOCK: FUSE_OPEN to FUSE_LOCKED, on a fuse write of 0 with no erase pulse in the same cycle.
- ERASE: FUSE_LOCKED to FUSE_OPEN, on the erase-complete pulse.

The reply state machine records which requester won the previous cycle. Its states are RSP_IDLE, RSP_INT, RSP_EXT and RSP_DBG, and every cycle it moves to the state of the new winner, or to RSP_IDLE when no request was granted.

Top module: `prg_gate_top`

## Requirements
- R1: The fuse output is active low: `fuse_bit`=1 means unprotected and 0 means protected, and `protect_on` is its inverse. After reset, `fuse_bit`=1 and `prog_valid`=0.
- R2: A fuse write with value 0 clears `fuse_bit` at the next clock edge. A fuse write with value 1 never changes `fuse_bit`, in either state.
- R3: An `erase_done` pulse sets `fuse_bit` to 1 and clears `prog_valid` at the same clock edge. It wins over a fuse clear write or a `prog_commit` pulse in the same cycle.
- R4: While protected, an external read with `ext_req_cfg`=0 (program memory) returns `ext_rsp_data`=0, and no memory read is issued for it.
- R5: While unprotected, an external program memory read returns the memory word at the requested address.
- R6: Internal reads return the true memory word whether or not protection is on.
- R7: External reads with `ext_req_cfg`=1 (configuration block) return the true word whether or not protection is on, with `mem_rd_cfg`=1 presented to the memory.
- R8: While protected, a debugger request is accepted and answered with `dbg_rsp_denied`=1 and data 0, and no memory read is issued. While unprotected, the debugger receives the true program memory word with `dbg_rsp_denied`=0.
- R9: At most one of the three ready outputs is high in a cycle. An internal request always wins, then the external request, then the debugger.
- R10: Every granted request gets its response valid for exactly the cycle after the grant, never in the grant cycle. Response data reads 0 whenever its valid is low.
- R11: A `prog_commit` pulse sets `prog_valid` at the next edge.
- R12: Masking uses the fuse value in the grant cycle. A read granted in the same cycle as a fuse clear write is unmasked, and reads granted afterwards are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_wr_en | input | 1 | Software write strobe for the protection fuse |
| fuse_wr_val | input | 1 | Value written to the fuse (only 0 takes effect) |
| erase_done | input | 1 | One-cycle pulse at the end of a full device erase |
| prog_commit | input | 1 | One-cycle pulse marking that a program image is present |
| fuse_bit | output | 1 | Fuse value, 0 = protected |
| protect_on | output | 1 | High while protection is active |
| prog_valid | output | 1 | Program image present |
| int_req_valid | input | 1 | Internal table-read request |
| int_req_addr | input | AW | Internal read word address |
| int_req_ready | output | 1 | Internal request granted this cycle |
| int_rsp_valid | output | 1 | Internal response valid |
| int_rsp_data | output | DW | Internal response data |
| ext_req_valid | input | 1 | Programmer read request |
| ext_req_addr | input | AW | Programmer read word address |
| ext_req_cfg | input | 1 | 1 = configuration block, 0 = program memory |
| ext_req_ready | output | 1 | Programmer request granted this cycle |
| ext_rsp_valid | output | 1 | Programmer response valid |
| ext_rsp_data | output | DW | Programmer response data |
| dbg_req_valid | input | 1 | Debugger read request |
| dbg_req_addr | input | AW | Debugger read word address |
| dbg_req_ready | output | 1 | Debugger request granted this cycle |
| dbg_rsp_valid | output | 1 | Debugger response valid |
| dbg_rsp_data | output | DW | Debugger response data |
| dbg_rsp_denied | output | 1 | Debugger response refused by protection |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory word address |
| mem_rd_cfg | output | 1 | Select configuration block instead of program array |
| mem_rd_data | input | DW | Memory read data, valid in the strobe cycle |

## Verification
The hardest case to reach from the ports is a fuse clear that lands in the same cycle as a programmer grant. The read has to use the old fuse value, and the next read has to use the new one. The bench drives the clear write and the external request on the same falling edge. It then issues a second read straight after and expects true data first and zeros second. The bench memory model returns a poison word whenever no read strobe is present, so a leak through a masked or denied path shows up as nonzero data. Contention is also covered: all three requesters are raised together, and the bench then withdraws the winner to expose the next one in priority order.

// File: rtl/prg_pkg.sv
package prg_pkg;

    typedef enum logic {
        FUSE_OPEN   = 1'b0,
        FUSE_LOCKED = 1'b1
    } fuse_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DBG  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_INT  = 2'd1,
        RSP_EXT  = 2'd2,
        RSP_DBG  = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/prg_fuse.sv
module prg_fuse
    import prg_pkg::*;
#(
    parameter bit RESET_OPEN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic erase_done,
    input  logic prog_commit,
    output logic fuse_bit,
    output logic prog_valid
);

    localparam fuse_state_e RESET_STATE = RESET_OPEN ? FUSE_OPEN : FUSE_LOCKED;

    fuse_state_e state_q, state_d;
    logic        lock_req;

    assign lock_req = wr_en && !wr_val && !erase_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FUSE_OPEN: begin
                if (lock_req) begin
                    state_d = FUSE_LOCKED;
                end
            end
            FUSE_LOCKED: begin
                if (erase_done) begin
                    state_d = FUSE_OPEN;
                end
            end
            default: state_d = FUSE_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_valid <= 1'b0;
        end else if (erase_done) begin
            prog_valid <= 1'b0;
        end else if (prog_commit) begin
            prog_valid <= 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            FUSE_OPEN:   fuse_bit = 1'b1;
            FUSE_LOCKED: fuse_bit = 1'b0;
            default:     fuse_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/prg_arb.sv
module prg_arb
    import prg_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          protect,
    input  logic          int_valid,
    input  logic [AW-1:0] int_addr,
    input  logic          ext_valid,
    input  logic [AW-1:0] ext_addr,
    input  logic          ext_cfg,
    input  logic          dbg_valid,
    input  logic [AW-1:0] dbg_addr,
    output logic          int_ready,
    output logic          ext_ready,
    output logic          dbg_ready,
    output src_e          grant,
    output logic          force_zero,
    output logic          deny,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_cfg
);

    always_comb begin
        if (int_valid) begin
            grant = SRC_INT;
        end else if (ext_valid) begin
            grant = SRC_EXT;
        end else if (dbg_valid) begin
            grant = SRC_DBG;
        end else begin
            grant = SRC_NONE;
        end
    end

    always_comb begin
        int_ready  = 1'b0;
        ext_ready  = 1'b0;
        dbg_ready  = 1'b0;
        force_zero = 1'b0;
        deny       = 1'b0;
        rd_en      = 1'b0;
        rd_addr    = '0;
        rd_cfg     = 1'b0;
        unique case (grant)
            SRC_NONE: begin
            end
            SRC_INT: begin
                int_ready = 1'b1;
                rd_en     = 1'b1;
                rd_addr   = int_addr;
            end
            SRC_EXT: begin
                ext_ready = 1'b1;
                if (protect && !ext_cfg) begin
                    force_zero = 1'b1;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = ext_addr;
                    rd_cfg  = ext_cfg;
                end
            end
            SRC_DBG: begin
                dbg_ready = 1'b1;
                if (protect) begin
                    force_zero = 1'b1;
                    deny       = 1'b1;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = dbg_addr;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/prg_resp.sv
module prg_resp
    import prg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  src_e          grant,
    input  logic          force_zero,
    input  logic          deny,
    input  logic [DW-1:0] mem_data,
    output logic          int_valid,
    output logic [DW-1:0] int_data,
    output logic          ext_valid,
    output logic [DW-1:0] ext_data,
    output logic          dbg_valid,
    output logic [DW-1:0] dbg_data,
    output logic          dbg_denied
);

    rsp_state_e    state_q, state_d;
    logic [DW-1:0] data_q;
    logic          deny_q;

    always_comb begin
        unique case (grant)
            SRC_NONE: state_d = RSP_IDLE;
            SRC_INT:  state_d = RSP_INT;
            SRC_EXT:  state_d = RSP_EXT;
            SRC_DBG:  state_d = RSP_DBG;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
            deny_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            data_q  <= (force_zero || grant == SRC_NONE) ? '0 : mem_data;
            deny_q  <= deny;
        end
    end

    always_comb begin
        int_valid  = 1'b0;
        ext_valid  = 1'b0;
        dbg_valid  = 1'b0;
        int_data   = '0;
        ext_data   = '0;
        dbg_data   = '0;
        dbg_denied = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
            end
            RSP_INT: begin
                int_valid = 1'b1;
                int_data  = data_q;
            end
            RSP_EXT: begin
                ext_valid = 1'b1;
                ext_data  = data_q;
            end
            RSP_DBG: begin
                dbg_valid  = 1'b1;
                dbg_data   = data_q;
                dbg_denied = deny_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/prg_gate_top.sv
module prg_gate_top
    import prg_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 16,
    parameter bit RESET_OPEN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fuse_wr_en,
    input  logic          fuse_wr_val,
    input  logic          erase_done,
    input  logic          prog_commit,
    output logic          fuse_bit,
    output logic          protect_on,
    output logic          prog_valid,
    input  logic          int_req_valid,
    input  logic [AW-1:0] int_req_addr,
    output logic          int_req_ready,
    output logic          int_rsp_valid,
    output logic [DW-1:0] int_rsp_data,
    input  logic          ext_req_valid,
    input  logic [AW-1:0] ext_req_addr,
    input  logic          ext_req_cfg,
    output logic          ext_req_ready,
    output logic          ext_rsp_valid,
    output logic [DW-1:0] ext_rsp_data,
    input  logic          dbg_req_valid,
    input  logic [AW-1:0] dbg_req_addr,
    output logic          dbg_req_ready,
    output logic          dbg_rsp_valid,
    output logic [DW-1:0] dbg_rsp_data,
    output logic          dbg_rsp_denied,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    output logic          mem_rd_cfg,
    input  logic [DW-1:0] mem_rd_data
);

    src_e grant;
    logic force_zero;
    logic deny;

    prg_fuse #(
        .RESET_OPEN(RESET_OPEN)
    ) u_fuse (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fuse_wr_en),
        .wr_val     (fuse_wr_val),
        .erase_done (erase_done),
        .prog_commit(prog_commit),
        .fuse_bit   (fuse_bit),
        .prog_valid (prog_valid)
    );

    assign protect_on = !fuse_bit;

    prg_arb #(
        .AW(AW)
    ) u_arb (
        .protect   (protect_on),
        .int_valid (int_req_valid),
        .int_addr  (int_req_addr),
        .ext_valid (ext_req_valid),
        .ext_addr  (ext_req_addr),
        .ext_cfg   (ext_req_cfg),
        .dbg_valid (dbg_req_valid),
        .dbg_addr  (dbg_req_addr),
        .int_ready (int_req_ready),
        .ext_ready (ext_req_ready),
        .dbg_ready (dbg_req_ready),
        .grant     (grant),
        .force_zero(force_zero),
        .deny      (deny),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .rd_cfg    (mem_rd_cfg)
    );

    prg_resp #(
        .DW(DW)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .force_zero(force_zero),
        .deny      (deny),
        .mem_data  (mem_rd_data),
        .int_valid (int_rsp_valid),
        .int_data  (int_rsp_data),
        .ext_valid (ext_rsp_valid),
        .ext_data  (ext_rsp_data),
        .dbg_valid (dbg_rsp_valid),
        .dbg_data  (dbg_rsp_data),
        .dbg_denied(dbg_rsp_denied)
    );

endmodule

// File: rtl/prg_gate_chk.sv
module prg_gate_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fuse_wr_en,
    input logic          fuse_wr_val,
    input logic          erase_done,
    input logic          prog_commit,
    input logic          fuse_bit,
    input logic          protect_on,
    input logic          prog_valid,
    input logic          int_req_valid,
    input logic          int_req_ready,
    input logic          int_rsp_valid,
    input logic          ext_req_ready,
    input logic          ext_req_cfg,
    input logic          ext_rsp_valid,
    input logic [DW-1:0] ext_rsp_data,
    input logic          dbg_req_ready,
    input logic          dbg_rsp_valid,
    input logic [DW-1:0] dbg_rsp_data,
    input logic          dbg_rsp_denied,
    input logic          mem_rd_en,
    input logic          mem_rd_cfg
);

    // R1: protect flag is the inverse of the active-low fuse
    assert_fuse_polarity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        protect_on != fuse_bit);

    // R2: once clear, the fuse stays clear until an erase pulse
    assert_fuse_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_bit && !erase_done) |=> !fuse_bit);

    // R2: a clear write with no erase locks the fuse
    assert_fuse_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_wr_en && !fuse_wr_val && !erase_done) |=> !fuse_bit);

    // R3: erase reopens the fuse and drops the image flag together
    assert_erase_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> (fuse_bit && !prog_valid));

    // R11: commit without erase sets the image flag
    assert_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_commit && !erase_done) |=> prog_valid);

    // R4: masked programmer reads return zero and never touch memory
    assert_ext_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_ready && !ext_req_cfg && protect_on) |-> (!mem_rd_en ##1 (ext_rsp_valid && ext_rsp_data == '0)));

    // R7: configuration reads reach the memory even while protected
    assert_cfg_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_ready && ext_req_cfg) |-> (mem_rd_en && mem_rd_cfg));

    // R8: denied debugger access issues no memory read
    assert_dbg_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_ready && protect_on) |-> (!mem_rd_en ##1 (dbg_rsp_valid && dbg_rsp_denied && dbg_rsp_data == '0)));

    // R9: a single grant per cycle, internal first
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_req_ready, ext_req_ready, dbg_req_ready}));

    assert_int_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_valid |-> int_req_ready);

    // R10: response follows the grant by one cycle
    assert_int_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_req_ready |=> int_rsp_valid);

    assert_ext_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_ready |=> ext_rsp_valid);

    assert_dbg_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req_ready |=> dbg_rsp_valid);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rsp_valid |-> (ext_rsp_data == '0));

endmodule

bind prg_gate_top prg_gate_chk #(
    .DW(DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fuse_wr_en    (fuse_wr_en),
    .fuse_wr_val   (fuse_wr_val),
    .erase_done    (erase_done),
    .prog_commit   (prog_commit),
    .fuse_bit      (fuse_bit),
    .protect_on    (protect_on),
    .prog_valid    (prog_valid),
    .int_req_valid (int_req_valid),
    .int_req_ready (int_req_ready),
    .int_rsp_valid (int_rsp_valid),
    .ext_req_ready (ext_req_ready),
    .ext_req_cfg   (ext_req_cfg),
    .ext_rsp_valid (ext_rsp_valid),
    .ext_rsp_data  (ext_rsp_data),
    .dbg_req_ready (dbg_req_ready),
    .dbg_rsp_valid (dbg_rsp_valid),
    .dbg_rsp_data  (dbg_rsp_data),
    .dbg_rsp_denied(dbg_rsp_denied),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_cfg    (mem_rd_cfg)
);

// File: tb/sim_prg_gate_top.sv
`timescale 1ns/1ps
module sim_prg_gate_top;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam logic [DW-1:0] POISON = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fuse_wr_en = 1'b0, fuse_wr_val = 1'b0, erase_done = 1'b0, prog_commit = 1'b0;
    logic          fuse_bit, protect_on, prog_valid;
    logic          int_req_valid = 1'b0, ext_req_valid = 1'b0, dbg_req_valid = 1'b0, ext_req_cfg = 1'b0;
    logic [AW-1:0] int_req_addr = '0, ext_req_addr = '0, dbg_req_addr = '0;
    logic          int_req_ready, ext_req_ready, dbg_req_ready;
    logic          int_rsp_valid, ext_rsp_valid, dbg_rsp_valid, dbg_rsp_denied;
    logic [DW-1:0] int_rsp_data, ext_rsp_data, dbg_rsp_data;
    logic          mem_rd_en, mem_rd_cfg;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // memory model: word = {tag nibble, address}; poison when not strobed
    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a, input logic cfg);
        return {(cfg ? 4'hC : 4'h3), a};
    endfunction

    assign mem_rd_data = mem_rd_en ? word_of(mem_rd_addr, mem_rd_cfg) : POISON;

    prg_gate_top #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fuse_wr_en(fuse_wr_en), .fuse_wr_val(fuse_wr_val),
        .erase_done(erase_done), .prog_commit(prog_commit),
        .fuse_bit(fuse_bit), .protect_on(protect_on), .prog_valid(prog_valid),
        .int_req_valid(int_req_valid), .int_req_addr(int_req_addr), .int_req_ready(int_req_ready),
        .int_rsp_valid(int_rsp_valid), .int_rsp_data(int_rsp_data),
        .ext_req_valid(ext_req_valid), .ext_req_addr(ext_req_addr), .ext_req_cfg(ext_req_cfg),
        .ext_req_ready(ext_req_ready), .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data),
        .dbg_req_valid(dbg_req_valid), .dbg_req_addr(dbg_req_addr), .dbg_req_ready(dbg_req_ready),
        .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_data(dbg_rsp_data), .dbg_rsp_denied(dbg_rsp_denied),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_cfg(mem_rd_cfg),
        .mem_rd_data(mem_rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one read through port which (0 int, 1 ext, 2 dbg); checks ready, latency, data, deny
    task automatic xfer(input int which, input logic [AW-1:0] a, input logic cfg,
                        input logic [DW-1:0] exp_d, input logic exp_den, input string req);
        logic rdy, rv;
        logic [DW-1:0] rd;
        @(negedge clk);
        int_req_valid = (which == 0); int_req_addr = a;
        ext_req_valid = (which == 1); ext_req_addr = a; ext_req_cfg = cfg;
        dbg_req_valid = (which == 2); dbg_req_addr = a;
        #1;
        rdy = (which == 0) ? int_req_ready : (which == 1) ? ext_req_ready : dbg_req_ready;
        rv  = (which == 0) ? int_rsp_valid : (which == 1) ? ext_rsp_valid : dbg_rsp_valid;
        check(rdy === 1'b1, "R9", "ready on lone request", {31'd0, rdy}, 32'd1);
        check(rv === 1'b0, "R10", "no response in grant cycle", {31'd0, rv}, 32'd0);
        @(negedge clk);
        int_req_valid = 1'b0; ext_req_valid = 1'b0; dbg_req_valid = 1'b0; ext_req_cfg = 1'b0;
        #1;
        rv = (which == 0) ? int_rsp_valid : (which == 1) ? ext_rsp_valid : dbg_rsp_valid;
        rd = (which == 0) ? int_rsp_data : (which == 1) ? ext_rsp_data : dbg_rsp_data;
        check(rv === 1'b1, "R10", "response one cycle after grant", {31'd0, rv}, 32'd1);
        check(rd === exp_d, req, "response data", {16'd0, rd}, {16'd0, exp_d});
        if (which == 2) begin
            check(dbg_rsp_denied === exp_den, "R8", "debug denial flag",
                  {31'd0, dbg_rsp_denied}, {31'd0, exp_den});
        end
    endtask

    task automatic fuse_write(input logic v, input logic er);
        @(negedge clk);
        fuse_wr_en = 1'b1; fuse_wr_val = v; erase_done = er;
        @(negedge clk);
        fuse_wr_en = 1'b0; erase_done = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        #1;
        check(fuse_bit === 1'b1, "R1", "fuse after reset", {31'd0, fuse_bit}, 32'd1);
        check(protect_on === 1'b0, "R1", "protect after reset", {31'd0, protect_on}, 32'd0);
        check(prog_valid === 1'b0, "R1", "image flag after reset", {31'd0, prog_valid}, 32'd0);
        check({int_rsp_valid, ext_rsp_valid, dbg_rsp_valid} === 3'b000, "R10", "no response after reset",
              {29'd0, int_rsp_valid, ext_rsp_valid, dbg_rsp_valid}, 32'd0);
    endtask

    task automatic t_commit();
        @(negedge clk); prog_commit = 1'b1;
        @(negedge clk); prog_commit = 1'b0; #1;
        check(prog_valid === 1'b1, "R11", "commit sets image flag", {31'd0, prog_valid}, 32'd1);
    endtask

    task automatic t_open_reads();
        xfer(1, 12'h123, 1'b0, word_of(12'h123, 1'b0), 1'b0, "R5");
        xfer(0, 12'h0F0, 1'b0, word_of(12'h0F0, 1'b0), 1'b0, "R6");
        xfer(1, 12'h007, 1'b1, word_of(12'h007, 1'b1), 1'b0, "R7");
        xfer(2, 12'hABC, 1'b0, word_of(12'hABC, 1'b0), 1'b0, "R8");
    endtask

    task automatic t_write_one_open();
        fuse_write(1'b1, 1'b0);
        check(fuse_bit === 1'b1, "R2", "write 1 while open", {31'd0, fuse_bit}, 32'd1);
    endtask

    // fuse clear and programmer read granted together: old value applies
    task automatic t_lock_race();
        @(negedge clk);
        fuse_wr_en = 1'b1; fuse_wr_val = 1'b0;
        ext_req_valid = 1'b1; ext_req_addr = 12'h055; ext_req_cfg = 1'b0;
        @(negedge clk);
        fuse_wr_en = 1'b0; ext_req_valid = 1'b0; #1;
        check(ext_rsp_data === word_of(12'h055, 1'b0), "R12", "read granted with clear write",
              {16'd0, ext_rsp_data}, {16'd0, word_of(12'h055, 1'b0)});
        check(fuse_bit === 1'b0, "R2", "clear write locks fuse", {31'd0, fuse_bit}, 32'd0);
        check(protect_on === 1'b1, "R1", "protect when fuse clear", {31'd0, protect_on}, 32'd1);
        xfer(1, 12'h055, 1'b0, '0, 1'b0, "R12");
    endtask

    task automatic t_locked_reads();
        xfer(1, 12'hFFF, 1'b0, '0, 1'b0, "R4");
        xfer(0, 12'h321, 1'b0, word_of(12'h321, 1'b0), 1'b0, "R6");
        xfer(1, 12'h002, 1'b1, word_of(12'h002, 1'b1), 1'b0, "R7");
        xfer(2, 12'h444, 1'b0, '0, 1'b1, "R8");
    endtask

    task automatic t_write_one_locked();
        fuse_write(1'b1, 1'b0);
        check(fuse_bit === 1'b0, "R2", "write 1 while locked", {31'd0, fuse_bit}, 32'd0);
        xfer(1, 12'h010, 1'b0, '0, 1'b0, "R4");
    endtask

    task automatic t_contend();
        @(negedge clk);
        int_req_valid = 1'b1; int_req_addr = 12'h111;
        ext_req_valid = 1'b1; ext_req_addr = 12'h222; ext_req_cfg = 1'b1;
        dbg_req_valid = 1'b1; dbg_req_addr = 12'h333;
        #1;
        check({int_req_ready, ext_req_ready, dbg_req_ready} === 3'b100, "R9", "internal wins",
              {29'd0, int_req_ready, ext_req_ready, dbg_req_ready}, 32'd4);
        @(negedge clk);
        int_req_valid = 1'b0; #1;
        check(int_rsp_data === word_of(12'h111, 1'b0), "R6", "internal data under contention",
              {16'd0, int_rsp_data}, {16'd0, word_of(12'h111, 1'b0)});
        check({int_req_ready, ext_req_ready, dbg_req_ready} === 3'b010, "R9", "external next",
              {29'd0, int_req_ready, ext_req_ready, dbg_req_ready}, 32'd2);
        @(negedge clk);
        ext_req_valid = 1'b0; ext_req_cfg = 1'b0; #1;
        check(ext_rsp_data === word_of(12'h222, 1'b1), "R7", "config data under contention",
              {16'd0, ext_rsp_data}, {16'd0, word_of(12'h222, 1'b1)});
        check({int_req_ready, ext_req_ready, dbg_req_ready} === 3'b001, "R9", "debugger last",
              {29'd0, int_req_ready, ext_req_ready, dbg_req_ready}, 32'd1);
        @(negedge clk);
        dbg_req_valid = 1'b0; #1;
        check(dbg_rsp_denied === 1'b1, "R8", "debugger denied under contention",
              {31'd0, dbg_rsp_denied}, 32'd1);
        check(ext_rsp_valid === 1'b0 && ext_rsp_data === '0, "R10", "idle response data zero",
              {15'd0, ext_rsp_valid, ext_rsp_data}, 32'd0);
    endtask

    task automatic t_erase();
        @(negedge clk);
        erase_done = 1'b1; prog_commit = 1'b1;
        @(negedge clk);
        erase_done = 1'b0; prog_commit = 1'b0; #1;
        check(fuse_bit === 1'b1, "R3", "erase reopens fuse", {31'd0, fuse_bit}, 32'd1);
        check(prog_valid === 1'b0, "R3", "erase clears image flag", {31'd0, prog_valid}, 32'd0);
        fuse_write(1'b0, 1'b1);
        check(fuse_bit === 1'b1, "R3", "erase wins over clear write", {31'd0, fuse_bit}, 32'd1);
        xfer(1, 12'h0AA, 1'b0, word_of(12'h0AA, 1'b0), 1'b0, "R5");
        xfer(2, 12'h0BB, 1'b0, word_of(12'h0BB, 1'b0), 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_commit();
        t_open_reads();
        t_write_one_open();
        t_lock_race();
        t_locked_reads();
        t_write_one_locked();
        t_contend();
        t_erase();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule